// File: doc/BRIEF.md
# Static Memory Strobe Sequencer

This block turns single-beat requests from an internal port into chip select, output enable and write enable strobes for one asynchronous static memory region. A request carries an address, write data, byte enables and a read/write flag. The block accepts it when `req_ready` is high and then runs the memory cycle. It ends the cycle with a one-cycle `rsp_done` pulse. For a read, the captured data is returned on `rsp_rdata` in the same cycle as that pulse.

All intervals are counted in core clock cycles, and the programmable values come in on plain configuration inputs. A write enable delay sets how many cycles pass between the fall of chip select and the fall of write enable. Separate read and write counts set the strobe lengths. When the long-access option is on, a single wider count replaces both of them.

A protection bit turns every write into an immediate error response with no bus activity, and reads are left unaffected. A buffer enable bit is passed to the pads for the length of each transfer. Configuration is taken only at the cycle in which a request is accepted. A change made while a transfer is running therefore applies to the next transfer.

Top module: `sram_seq`

## Requirements
- R1: After reset `mem_cs_n`, `mem_oe_n` and `mem_we_n` are 1, `req_ready` is 1 and `rsp_done` is 0.
- R2: `req_ready` is 1 only while the sequencer is idle. It is 0 in every cycle in which `mem_cs_n` is 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: In a read, `mem_cs_n` and `mem_oe_n` fall together and stay 0 for `cfg_rd_wait`+1 cycles. In the next cycle both are 1, `rsp_done` is 1, and `rsp_rdata` holds the `mem_rdata` value present in the last strobe cycle.
- R4: In a write, `mem_we_n` falls `cfg_wen_dly`+1 cycles after `mem_cs_n` falls. A setting of 0 gives exactly one cycle.
- R5: In a write, `mem_we_n` stays 0 for `cfg_wr_wait`+1 cycles and rises one cycle before `mem_cs_n` rises. `rsp_done` is 1 in the first cycle with `mem_cs_n` high, so chip select is low for `cfg_wen_dly`+`cfg_wr_wait`+3 cycles.
- R6: While `cfg_ext_en` is 1, the read strobe and the write enable strobe last `cfg_ext_wait`+1 cycles instead of the separate counts. Clearing it restores the separate counts.
- R7: When `cfg_wprot` is 1, an accepted write produces `rsp_done`=1 and `rsp_err`=1 in the next cycle, and no strobe goes low. Reads still run normally. `rsp_err` is 0 for every other completion.
- R8: All configuration inputs are sampled at the accepting edge. A change made during a transfer does not alter that transfer and is used by the next one.
- R9: `mem_buf_en` equals the `cfg_buf_en` value sampled at acceptance while `mem_cs_n` is 0, and is 0 otherwise.
- R10: During a transfer `mem_addr` and `mem_wdata` carry the request values, and `mem_be_n` is the bitwise inverse of `req_be` (active low). Outside a transfer `mem_be_n` is all ones.
- R11: `mem_oe_n` and `mem_we_n` are never 0 in the same cycle, and `mem_we_n` is 0 only while `mem_cs_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables, active high |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Write refused by protection, with done |
| rsp_rdata | output | DATA_W | Read data |
| cfg_wen_dly | input | DLY_W | Chip select to write enable delay minus one |
| cfg_rd_wait | input | WAIT_W | Read strobe length minus one |
| cfg_wr_wait | input | WAIT_W | Write strobe length minus one |
| cfg_ext_wait | input | EXT_W | Long strobe length minus one |
| cfg_ext_en | input | 1 | Use the long count for reads and writes |
| cfg_wprot | input | 1 | Refuse writes |
| cfg_buf_en | input | 1 | Buffer enable for the pads |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Byte lane selects, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_buf_en | output | 1 | Buffer enable during a transfer |

## Verification
The bench builds the block with 16-bit address and data, a 4-bit write enable delay, 5-bit read and write counts and a 10-bit long count, with the long-access variant generated in. With these widths the bench can reach the largest delay (15) and the largest short count (31) in one write. It can also run a long-count access of 41 cycles, longer than any short count allows. Protected writes, configuration changed during a running transfer, and switching between short and long counts are run with several byte-enable patterns.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WSETUP,
      ST_WSTROBE,
      ST_WHOLD
   } seq_state_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_seq_cnt.sv
module sram_seq_cnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/sram_seq_cfg.sv
module sram_seq_cfg #(
   parameter int DLY_W   = 4,
   parameter int WAIT_W  = 5,
   parameter int EXT_W   = 10,
   parameter int CNT_W   = 10,
   parameter bit HAS_EXT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic [DLY_W-1:0]  cfg_wen_dly,
   input  logic [WAIT_W-1:0] cfg_rd_wait,
   input  logic [WAIT_W-1:0] cfg_wr_wait,
   input  logic [EXT_W-1:0]  cfg_ext_wait,
   input  logic              cfg_ext_en,
   input  logic              cfg_buf_en,
   output logic [CNT_W-1:0]  dly_now,
   output logic [CNT_W-1:0]  rd_now,
   output logic [CNT_W-1:0]  wr_q,
   output logic              buf_q
);
   logic [CNT_W-1:0] wr_now;

   assign dly_now = CNT_W'(cfg_wen_dly);

   generate
      if (HAS_EXT) begin : g_ext
         assign rd_now = cfg_ext_en ? CNT_W'(cfg_ext_wait) : CNT_W'(cfg_rd_wait);
         assign wr_now = cfg_ext_en ? CNT_W'(cfg_ext_wait) : CNT_W'(cfg_wr_wait);
      end else begin : g_noext
         assign rd_now = CNT_W'(cfg_rd_wait);
         assign wr_now = CNT_W'(cfg_wr_wait);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         buf_q <= 1'b0;
      end else if (take) begin
         wr_q  <= wr_now;
         buf_q <= cfg_buf_en;
      end
   end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int CNT_W  = 10,
   localparam int BE_W  = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   input  logic              cfg_wprot,
   input  logic [CNT_W-1:0]  dly_now,
   input  logic [CNT_W-1:0]  rd_now,
   input  logic [CNT_W-1:0]  wr_q,
   input  logic              cnt_zero,
   output logic              take,
   output logic              cnt_load,
   output logic [CNT_W-1:0]  cnt_val,
   output logic              req_ready,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [BE_W-1:0]   be_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   input  logic [DATA_W-1:0] mem_rdata
);
   seq_state_e state;
   logic       refuse;

   assign req_ready = (state == ST_IDLE);
   assign take      = req_valid && req_ready;
   assign refuse    = req_write && cfg_wprot;

   always_comb begin
      cnt_load = 1'b0;
      cnt_val  = '0;
      if (take && !refuse) begin
         cnt_load = 1'b1;
         cnt_val  = req_write ? dly_now : rd_now;
      end else if (state == ST_WSETUP && cnt_zero) begin
         cnt_load = 1'b1;
         cnt_val  = wr_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         mem_cs_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         rsp_done  <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
         be_q      <= '0;
         addr_q    <= '0;
         wdata_q   <= '0;
      end else begin
         rsp_done <= 1'b0;
         rsp_err  <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (take) begin
                  if (refuse) begin
                     rsp_done <= 1'b1;
                     rsp_err  <= 1'b1;
                  end else begin
                     addr_q   <= req_addr;
                     wdata_q  <= req_wdata;
                     be_q     <= req_be;
                     mem_cs_n <= 1'b0;
                     if (req_write) begin
                        state <= ST_WSETUP;
                     end else begin
                        mem_oe_n <= 1'b0;
                        state    <= ST_READ;
                     end
                  end
               end
            end
            ST_READ: begin
               if (cnt_zero) begin
                  rsp_rdata <= mem_rdata;
                  mem_cs_n  <= 1'b1;
                  mem_oe_n  <= 1'b1;
                  rsp_done  <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            ST_WSETUP: begin
               if (cnt_zero) begin
                  mem_we_n <= 1'b0;
                  state    <= ST_WSTROBE;
               end
            end
            ST_WSTROBE: begin
               if (cnt_zero) begin
                  mem_we_n <= 1'b1;
                  state    <= ST_WHOLD;
               end
            end
            ST_WHOLD: begin
               mem_cs_n <= 1'b1;
               rsp_done <= 1'b1;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int DATA_W  = 16,
   parameter int DLY_W   = 4,
   parameter int WAIT_W  = 5,
   parameter int EXT_W   = 10,
   parameter bit HAS_EXT = 1'b1,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              req_ready,
   output logic              rsp_done,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   input  logic [DLY_W-1:0]  cfg_wen_dly,
   input  logic [WAIT_W-1:0] cfg_rd_wait,
   input  logic [WAIT_W-1:0] cfg_wr_wait,
   input  logic [EXT_W-1:0]  cfg_ext_wait,
   input  logic              cfg_ext_en,
   input  logic              cfg_wprot,
   input  logic              cfg_buf_en,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [BE_W-1:0]   mem_be_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_buf_en
);
   localparam int CNT_W = int'(max3(DLY_W, WAIT_W, EXT_W));

   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
         initial $fatal(1, "sram_seq: DATA_W must be a positive multiple of 8");
      end
      if (DLY_W < 1 || WAIT_W < 1 || EXT_W < 1) begin : g_bad_cnt_w
         initial $fatal(1, "sram_seq: timing field widths must be at least 1");
      end
   endgenerate

   logic             take, cnt_load, cnt_zero, buf_q;
   logic [CNT_W-1:0] cnt_val, dly_now, rd_now, wr_q;
   logic [BE_W-1:0]  be_q;

   sram_seq_cfg #(
      .DLY_W(DLY_W), .WAIT_W(WAIT_W), .EXT_W(EXT_W), .CNT_W(CNT_W), .HAS_EXT(HAS_EXT)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .take(take),
      .cfg_wen_dly(cfg_wen_dly), .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
      .cfg_ext_wait(cfg_ext_wait), .cfg_ext_en(cfg_ext_en), .cfg_buf_en(cfg_buf_en),
      .dly_now(dly_now), .rd_now(rd_now), .wr_q(wr_q), .buf_q(buf_q)
   );

   sram_seq_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
   );

   sram_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_be(req_be), .cfg_wprot(cfg_wprot),
      .dly_now(dly_now), .rd_now(rd_now), .wr_q(wr_q), .cnt_zero(cnt_zero),
      .take(take), .cnt_load(cnt_load), .cnt_val(cnt_val),
      .req_ready(req_ready), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .be_q(be_q), .addr_q(mem_addr), .wdata_q(mem_wdata), .mem_rdata(mem_rdata)
   );

   assign mem_be_n   = mem_cs_n ? {BE_W{1'b1}} : ~be_q;
   assign mem_buf_en = buf_q & ~mem_cs_n;
endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_write,
   input logic req_ready,
   input logic cfg_wprot,
   input logic mem_cs_n,
   input logic mem_oe_n,
   input logic mem_we_n,
   input logic mem_buf_en,
   input logic rsp_done,
   input logic rsp_err
);
   a_r11_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);

   a_r11_no_oe_we_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_cs_n);

   a_r7_protected_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_write && cfg_wprot) |=> (rsp_done && rsp_err && mem_cs_n));

   a_r5_we_rises_before_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |=> $rose(mem_cs_n));

   a_r5_done_with_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_cs_n) |-> (rsp_done && !rsp_err));

   a_r3_oe_falls_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> $fell(mem_cs_n));

   a_r9_buf_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      mem_buf_en |-> !mem_cs_n);

   a_r7_err_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_done);
endmodule

bind sram_seq sram_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_ready(req_ready), .cfg_wprot(cfg_wprot), .mem_cs_n(mem_cs_n),
   .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_buf_en(mem_buf_en),
   .rsp_done(rsp_done), .rsp_err(rsp_err)
);

// File: tb/sim_sram_seq.sv
module sim_sram_seq;
   localparam int AW = 16, DW = 16, BW = 2, LW = 4, WW = 5, EW = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [BW-1:0] req_be = '0;
   logic req_ready, rsp_done, rsp_err;
   logic [DW-1:0] rsp_rdata;
   logic [LW-1:0] cfg_wen_dly = '0;
   logic [WW-1:0] cfg_rd_wait = '0, cfg_wr_wait = '0;
   logic [EW-1:0] cfg_ext_wait = '0;
   logic cfg_ext_en = 1'b0, cfg_wprot = 1'b0, cfg_buf_en = 1'b0;
   logic mem_cs_n, mem_oe_n, mem_we_n, mem_buf_en;
   logic [BW-1:0] mem_be_n;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   always #5 clk = ~clk;

   assign mem_rdata = mem_oe_n ? '0 : (mem_addr ^ 16'h5A3C);

   sram_seq #(.ADDR_W(AW), .DATA_W(DW), .DLY_W(LW), .WAIT_W(WW), .EXT_W(EW), .HAS_EXT(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
      .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .cfg_wen_dly(cfg_wen_dly), .cfg_rd_wait(cfg_rd_wait), .cfg_wr_wait(cfg_wr_wait),
      .cfg_ext_wait(cfg_ext_wait), .cfg_ext_en(cfg_ext_en), .cfg_wprot(cfg_wprot),
      .cfg_buf_en(cfg_buf_en), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_buf_en(mem_buf_en)
   );

   typedef struct {
      string         tag;
      logic          wr;
      logic          err;
      int            cs_len;
      int            we_pre;
      int            we_len;
      int            oe_len;
      logic [DW-1:0] rdata;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
      logic [BW-1:0] be_n;
      logic          bufe;
   } exp_t;

   exp_t q[$];
   int checks = 0, fails = 0;

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic issue(input string tag, input logic wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [BW-1:0] be);
      exp_t e;
      int rdlen, wrlen;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      rdlen = (cfg_ext_en ? int'(cfg_ext_wait) : int'(cfg_rd_wait)) + 1;
      wrlen = (cfg_ext_en ? int'(cfg_ext_wait) : int'(cfg_wr_wait)) + 1;
      e.tag = tag; e.wr = wr; e.addr = a; e.wdata = d; e.be_n = ~be; e.bufe = cfg_buf_en;
      e.rdata = a ^ 16'h5A3C;
      e.err = wr && cfg_wprot;
      e.we_pre = 0; e.we_len = 0; e.oe_len = 0; e.cs_len = 0;
      if (!e.err) begin
         if (wr) begin
            e.we_pre = int'(cfg_wen_dly) + 1;
            e.we_len = wrlen;
            e.cs_len = int'(cfg_wen_dly) + 2 + wrlen;
         end else begin
            e.oe_len = rdlen;
            e.cs_len = rdlen;
         end
      end
      q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Monitor: measures strobes per transfer, pops the scoreboard on each done pulse.
   int cs_cnt = 0, we_cnt = 0, oe_cnt = 0, we_pre = 0;
   logic overlap = 1'b0, rdy_busy = 1'b0, buf_seen = 1'b0;
   logic [AW-1:0] a_seen = '0;
   logic [DW-1:0] d_seen = '0;
   logic [BW-1:0] be_seen = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_cs_n) begin
            if (cs_cnt == 0) begin
               a_seen = mem_addr; d_seen = mem_wdata; be_seen = mem_be_n;
               buf_seen = mem_buf_en; rdy_busy = req_ready;
            end
            cs_cnt++;
            if (!mem_we_n) begin
               if (we_cnt == 0) we_pre = cs_cnt - 1;
               we_cnt++;
            end
            if (!mem_oe_n) oe_cnt++;
            if (!mem_oe_n && !mem_we_n) overlap = 1'b1;
         end else if (!mem_we_n || !mem_oe_n) begin
            overlap = 1'b1;
         end
         if (rsp_done) begin
            if (q.size() == 0) begin
               chk("R2", "unexpected done", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(e.err ? "R7" : e.tag, "err flag", rsp_err, e.err);
               chk(e.err ? "R7" : e.tag, "cs low cycles", cs_cnt, e.cs_len);
               chk(e.tag, "oe low cycles", oe_cnt, e.oe_len);
               chk(e.tag, "we low cycles", we_cnt, e.we_len);
               chk("R11", "oe/we overlap", overlap, 0);
               if (!e.err) begin
                  chk("R2", "ready during transfer", rdy_busy, 0);
                  chk("R10", "address", a_seen, e.addr);
                  chk("R10", "byte lanes", be_seen, e.be_n);
                  chk("R9", "buffer enable", buf_seen, e.bufe);
                  if (e.wr) begin
                     chk("R4", "cs to we cycles", we_pre, e.we_pre);
                     chk("R10", "write data", d_seen, e.wdata);
                  end else begin
                     chk("R3", "read data", rsp_rdata, e.rdata);
                  end
               end
            end
            cs_cnt = 0; we_cnt = 0; oe_cnt = 0; we_pre = 0; overlap = 1'b0;
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "cs_n", mem_cs_n, 1); chk("R1", "oe_n", mem_oe_n, 1);
      chk("R1", "we_n", mem_we_n, 1); chk("R1", "ready", req_ready, 1);
      chk("R1", "done", rsp_done, 0);
      rst_n = 1'b1;

      // R3 reads with short counts
      cfg_rd_wait = 5'd0; issue("R3", 1'b0, 16'h0011, 16'h0, 2'b11);
      cfg_rd_wait = 5'd3; issue("R3", 1'b0, 16'h1234, 16'h0, 2'b01);
      // R4 / R5 writes, delay 0 and limits
      cfg_wen_dly = 4'd0; cfg_wr_wait = 5'd0; issue("R4", 1'b1, 16'h0100, 16'hBEEF, 2'b11);
      cfg_wen_dly = 4'd5; cfg_wr_wait = 5'd2; issue("R5", 1'b1, 16'h0200, 16'hC0DE, 2'b10);
      cfg_wen_dly = 4'd15; cfg_wr_wait = 5'd31; issue("R5", 1'b1, 16'hFFFE, 16'h8001, 2'b01);
      // R6 long count for both directions, then back to short counts
      cfg_ext_en = 1'b1; cfg_ext_wait = 10'd40; cfg_wen_dly = 4'd2;
      issue("R6", 1'b0, 16'h0AA0, 16'h0, 2'b11);
      issue("R6", 1'b1, 16'h0AA2, 16'h5555, 2'b11);
      cfg_ext_wait = 10'd0; issue("R6", 1'b0, 16'h0AA4, 16'h0, 2'b11);
      cfg_ext_en = 1'b0; cfg_rd_wait = 5'd2; issue("R6", 1'b0, 16'h0AA6, 16'h0, 2'b11);
      // R7 protection
      cfg_wprot = 1'b1;
      issue("R7", 1'b1, 16'h0300, 16'h1111, 2'b11);
      issue("R7", 1'b1, 16'h0302, 16'h2222, 2'b11);
      issue("R7", 1'b0, 16'h0304, 16'h0, 2'b11);
      cfg_wprot = 1'b0; cfg_wen_dly = 4'd1; cfg_wr_wait = 5'd1;
      issue("R7", 1'b1, 16'h0306, 16'h3333, 2'b11);
      // R8 configuration changed during a transfer
      cfg_rd_wait = 5'd6; issue("R8", 1'b0, 16'h0400, 16'h0, 2'b11);
      cfg_rd_wait = 5'd1; cfg_ext_en = 1'b1; cfg_ext_wait = 10'd9; cfg_buf_en = 1'b1;
      issue("R8", 1'b0, 16'h0402, 16'h0, 2'b11);
      cfg_ext_en = 1'b0; cfg_wen_dly = 4'd3; cfg_wr_wait = 5'd4;
      issue("R8", 1'b1, 16'h0404, 16'h4444, 2'b10);
      cfg_wen_dly = 4'd0; cfg_wr_wait = 5'd0; cfg_buf_en = 1'b0;
      // R9 / R10 buffer enable and byte lanes
      cfg_buf_en = 1'b1; issue("R9", 1'b1, 16'h0500, 16'hA5A5, 2'b01);
      cfg_buf_en = 1'b0; issue("R10", 1'b0, 16'h0502, 16'h0, 2'b10);

      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R1", "idle cs_n at end", mem_cs_n, 1);
      chk("R10", "idle byte lanes", mem_be_n, 2'b11);
      finish_run();
   end
endmodule